// File: doc/BRIEF.md
# Selectable Victim Way Picker

This block picks the way to replace within one set of an N-way set-associative cache. It tracks two orders for the set. The placement order changes only on fills. The access order changes on both fills and hits. A run-time policy input chooses which order is read, and which end of it supplies the victim. Three policies are offered: evict the newest fill (stack-like), evict the oldest fill (queue-like), or evict the least recently touched way.

The block keeps a valid bit for each way. A fill sets the bit and an invalidate clears it. Any empty way is taken ahead of the active policy.

A victim is asked for with a valid/ready handshake. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. The chosen way appears on `out_way` one cycle later, with `out_valid` high. It stays there unchanged until the consumer raises `out_ready`. The block accepts a new request whenever its response register is empty, or is being emptied in the same cycle. A system with many sets uses one copy per set.

Top module: `victim_pick`

## Requirements
- R1: When at least one way is invalid, the victim is the lowest-numbered invalid way, whatever the policy.
- R2: With policy 2'b10 and all ways valid, the victim is the way filled most recently, and hits do not change it.
- R3: With policy 2'b01 and all ways valid, the victim is the way whose fill is oldest, and hits do not change it.
- R4: With policy 2'b00 and all ways valid, the victim is the way whose latest fill or hit is oldest.
- R5: A fill makes its way the newest in both the placement order and the access order.
- R6: Policy 2'b11 behaves as 2'b00. Changing the policy never alters either order; it only selects which order is consulted.
- R7: An invalidate clears that way's valid bit. A fill to the same way in the same cycle wins, and the way stays valid.
- R8: A hit in the same cycle as a fill is ignored.
- R9: A request accepted on an edge gives `out_valid` high after that edge. `out_way` holds steady while `out_ready` is low. `req_ready` is high whenever `out_valid` is low or `out_ready` is high.
- R10: The victim reflects the state before any fill, hit or invalidate presented in the same cycle as the request.
- R11: After reset, no way is valid, `out_valid` is low and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fill_en | input | 1 | A line is installed this cycle |
| fill_way | input | IDX_W | Way being installed |
| hit_en | input | 1 | A lookup hit this cycle |
| hit_way | input | IDX_W | Way that hit |
| inval_en | input | 1 | Invalidate a way this cycle |
| inval_way | input | IDX_W | Way to invalidate |
| policy | input | 2 | 00 LRU, 01 oldest fill, 10 newest fill, 11 LRU |
| req_valid | input | 1 | Victim request |
| req_ready | output | 1 | Request can be taken |
| out_valid | output | 1 | Victim result present |
| out_ready | input | 1 | Consumer takes the result |
| out_way | output | IDX_W | Chosen victim way |

## Verification
The bench builds the block with its default of four ways and a two-bit way index. Four ways is enough to fill the set in a non-sequential order, so the placement order, the access order and the way numbers all differ. That lets the three policies give three distinct victims from the same state. It also makes room for a set that is partly empty, for refills of a valid way, and for an invalidate that collides with a fill in the same cycle. Stalling the consumer while requests are pending exercises the result hold and the return of `req_ready`.

// File: rtl/vsel_pkg.sv
package vsel_pkg;
  typedef enum logic [1:0] {
    POL_LRU    = 2'b00,
    POL_OLDEST = 2'b01,
    POL_NEWEST = 2'b10,
    POL_LRU2   = 2'b11
  } policy_e;
endpackage

// File: rtl/order_track.sv
// Keeps a rank per way: 0 = most recent touch, WAYS-1 = oldest.
module order_track #(
  parameter int WAYS  = 4,
  parameter int IDX_W = $clog2(WAYS)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       touch_en,
  input  logic [IDX_W-1:0]           touch_way,
  output logic [WAYS-1:0][IDX_W-1:0] rank
);
  logic [IDX_W-1:0] touched_rank;

  assign touched_rank = rank[touch_way];

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        rank[w] <= IDX_W'(w);
      end else if (touch_en) begin
        if (IDX_W'(w) == touch_way) begin
          rank[w] <= '0;
        end else if (rank[w] < touched_rank) begin
          rank[w] <= rank[w] + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/victim_choose.sv
module victim_choose
  import vsel_pkg::*;
#(
  parameter int WAYS  = 4,
  parameter int IDX_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0]            valid,
  input  logic [WAYS-1:0][IDX_W-1:0] ins_rank,
  input  logic [WAYS-1:0][IDX_W-1:0] use_rank,
  input  policy_e                    policy,
  output logic [IDX_W-1:0]           victim
);
  localparam logic [IDX_W-1:0] OLDEST = IDX_W'(WAYS - 1);

  logic [IDX_W-1:0] empty_way;
  logic [IDX_W-1:0] policy_way;

  // Downward scan so the lowest empty way is the one kept.
  always_comb begin
    empty_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!valid[w]) empty_way = IDX_W'(w);
    end
  end

  always_comb begin
    policy_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      unique case (policy)
        POL_NEWEST: if (ins_rank[w] == '0)    policy_way = IDX_W'(w);
        POL_OLDEST: if (ins_rank[w] == OLDEST) policy_way = IDX_W'(w);
        default:    if (use_rank[w] == OLDEST) policy_way = IDX_W'(w);
      endcase
    end
  end

  assign victim = (&valid) ? policy_way : empty_way;
endmodule

// File: rtl/victim_pick.sv
module victim_pick
  import vsel_pkg::*;
#(
  parameter int WAYS  = 4,
  parameter int IDX_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fill_en,
  input  logic [IDX_W-1:0] fill_way,
  input  logic             hit_en,
  input  logic [IDX_W-1:0] hit_way,
  input  logic             inval_en,
  input  logic [IDX_W-1:0] inval_way,
  input  logic [1:0]       policy,
  input  logic             req_valid,
  output logic             req_ready,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [IDX_W-1:0] out_way
);
  logic [WAYS-1:0]            valid_q;
  logic [WAYS-1:0][IDX_W-1:0] ins_rank;
  logic [WAYS-1:0][IDX_W-1:0] use_rank;
  logic                       use_touch;
  logic [IDX_W-1:0]           use_way;
  logic [IDX_W-1:0]           pick;
  logic                       accept;

  // A fill outranks a hit in the same cycle.
  assign use_touch = fill_en | hit_en;
  assign use_way   = fill_en ? fill_way : hit_way;

  order_track #(.WAYS(WAYS), .IDX_W(IDX_W)) u_ins (
    .clk(clk), .rst_n(rst_n), .touch_en(fill_en), .touch_way(fill_way),
    .rank(ins_rank)
  );

  order_track #(.WAYS(WAYS), .IDX_W(IDX_W)) u_use (
    .clk(clk), .rst_n(rst_n), .touch_en(use_touch), .touch_way(use_way),
    .rank(use_rank)
  );

  victim_choose #(.WAYS(WAYS), .IDX_W(IDX_W)) u_choose (
    .valid(valid_q), .ins_rank(ins_rank), .use_rank(use_rank),
    .policy(policy_e'(policy)), .victim(pick)
  );

  for (genvar w = 0; w < WAYS; w++) begin : g_valid
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        valid_q[w] <= 1'b0;
      end else if (fill_en && fill_way == IDX_W'(w)) begin
        valid_q[w] <= 1'b1;
      end else if (inval_en && inval_way == IDX_W'(w)) begin
        valid_q[w] <= 1'b0;
      end
    end
  end

  assign req_ready = !out_valid || out_ready;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_way   <= '0;
    end else if (accept) begin
      out_valid <= 1'b1;
      out_way   <= pick;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/vsel_checker.sv
module vsel_checker #(
  parameter int WAYS  = 4,
  parameter int IDX_W = $clog2(WAYS)
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       fill_en,
  input logic [IDX_W-1:0]           fill_way,
  input logic                       hit_en,
  input logic                       inval_en,
  input logic [IDX_W-1:0]           inval_way,
  input logic                       req_valid,
  input logic                       req_ready,
  input logic                       out_valid,
  input logic                       out_ready,
  input logic [IDX_W-1:0]           out_way,
  input logic [WAYS-1:0]            valid_q,
  input logic [WAYS-1:0][IDX_W-1:0] ins_rank,
  input logic [WAYS-1:0][IDX_W-1:0] use_rank
);
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_way));

  a_r9_response: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> out_valid);

  a_r5_fill_newest: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en |=> ins_rank[$past(fill_way)] == '0 && use_rank[$past(fill_way)] == '0);

  // R2 and R3: hits leave the placement order alone.
  a_r3_hit_keeps_placement: assert property (@(posedge clk) disable iff (!rst_n)
    hit_en && !fill_en |=> $stable(ins_rank));

  a_r6_orders_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !fill_en && !hit_en |=> $stable(ins_rank) && $stable(use_rank));

  a_r7_inval_clears: assert property (@(posedge clk) disable iff (!rst_n)
    inval_en && !(fill_en && fill_way == inval_way) |=> !valid_q[$past(inval_way)]);

  a_r7_fill_sets: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en |=> valid_q[$past(fill_way)]);
endmodule

bind victim_pick vsel_checker #(.WAYS(WAYS), .IDX_W(IDX_W)) u_vsel_chk (.*);

// File: tb/test_victim_pick.sv
`timescale 1ns/1ps
module test_victim_pick;
  localparam int WAYS  = 4;
  localparam int IDX_W = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fill_en = 0, hit_en = 0, inval_en = 0, req_valid = 0, out_ready = 1;
  logic [IDX_W-1:0] fill_way = '0, hit_way = '0, inval_way = '0;
  logic [1:0] policy = 2'b00;
  logic req_ready, out_valid;
  logic [IDX_W-1:0] out_way;

  int checks = 0;
  int errors = 0;

  // Bench-side model: timestamps per way.
  int  fill_t[WAYS];
  int  use_t[WAYS];
  bit  vld[WAYS];
  int  tnow = 0;

  int    exp_q[$];
  string tag_q[$];

  always #5 clk = ~clk;

  victim_pick #(.WAYS(WAYS), .IDX_W(IDX_W)) i_victim_pick (
    .clk(clk), .rst_n(rst_n), .fill_en(fill_en), .fill_way(fill_way),
    .hit_en(hit_en), .hit_way(hit_way), .inval_en(inval_en),
    .inval_way(inval_way), .policy(policy), .req_valid(req_valid),
    .req_ready(req_ready), .out_valid(out_valid), .out_ready(out_ready),
    .out_way(out_way)
  );

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, expv);
    end
  endtask

  function automatic int model_pick();
    int best;
    for (int w = 0; w < WAYS; w++) if (!vld[w]) return w;
    best = 0;
    for (int w = 1; w < WAYS; w++) begin
      case (policy)
        2'b10:   if (fill_t[w] > fill_t[best]) best = w;
        2'b01:   if (fill_t[w] < fill_t[best]) best = w;
        default: if (use_t[w]  < use_t[best])  best = w;
      endcase
    end
    return best;
  endfunction

  // Driver: one cycle of stimulus; the expected victim uses the state before this cycle.
  task automatic cyc(input bit fe, input int fw, input bit he, input int hw,
                     input bit ie, input int iw, input bit rq, input string tag);
    @(negedge clk);
    if (rq) begin
      exp_q.push_back(model_pick());
      tag_q.push_back(tag);
    end
    fill_en = fe; fill_way = IDX_W'(fw);
    hit_en = he;  hit_way = IDX_W'(hw);
    inval_en = ie; inval_way = IDX_W'(iw);
    req_valid = rq;
    if (ie) vld[iw] = 0;
    if (fe) begin
      tnow++; fill_t[fw] = tnow; use_t[fw] = tnow; vld[fw] = 1;
    end else if (he) begin
      tnow++; use_t[hw] = tnow;
    end
    @(posedge clk); #1;
    fill_en = 0; hit_en = 0; inval_en = 0; req_valid = 0;
  endtask

  task automatic fill(input int w);
    cyc(1, w, 0, 0, 0, 0, 0, "R5");
  endtask
  task automatic hit(input int w);
    cyc(0, 0, 1, w, 0, 0, 0, "R4");
  endtask
  task automatic ask(input string tag);
    cyc(0, 0, 0, 0, 0, 0, 1, tag);
  endtask

  // Monitor: compares each result on the cycle it is handed over.
  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      if (exp_q.size() == 0) begin
        check(0, "R9 unexpected result", int'(out_way), -1);
      end else begin
        int    e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(int'(out_way) == e, t, int'(out_way), e);
      end
    end
  end

  initial begin
    fork
      begin
        repeat (5000) @(posedge clk);
        check(0, "watchdog", 0, 1);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    join_none

    for (int w = 0; w < WAYS; w++) begin
      vld[w] = 0; fill_t[w] = 0; use_t[w] = 0;
    end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R11 out_valid", int'(out_valid), 0);
    check(req_ready == 1'b1, "R11 req_ready", int'(req_ready), 1);

    ask("R11 empty set gives way 0");
    fill(0);
    ask("R1 lowest empty");
    fill(2);
    ask("R1 lowest empty after gap");
    fill(1);
    ask("R1 last empty");
    fill(3);

    policy = 2'b10;
    ask("R2 newest fill");
    hit(0); hit(3);
    ask("R2 hits ignored");

    policy = 2'b01;
    ask("R3 oldest fill");
    hit(2);
    ask("R3 hits ignored");

    policy = 2'b00;
    ask("R4 least recent");
    hit(1);
    ask("R4 after hit");
    policy = 2'b11;
    ask("R6 code 11 acts as LRU");
    policy = 2'b01;
    ask("R6 switch keeps placement order");

    fill(0);
    ask("R5 refill leaves oldest fill");
    policy = 2'b10;
    ask("R5 refill is newest");
    policy = 2'b00;
    ask("R5 refill is newest in access order");

    cyc(1, 2, 1, 3, 0, 0, 0, "R8");
    ask("R8 same-cycle hit ignored");

    policy = 2'b01;
    cyc(1, 1, 0, 0, 0, 0, 1, "R10 request with same-cycle fill");
    ask("R10 after fill applied");

    cyc(0, 0, 0, 0, 1, 3, 0, "R7");
    ask("R7 invalidated way preferred");
    cyc(1, 3, 0, 0, 1, 3, 0, "R7");
    cyc(1, 1, 0, 0, 1, 1, 0, "R7");
    policy = 2'b10;
    ask("R7 fill beats invalidate");

    // Back-pressure: hold the result while the consumer stalls.
    @(posedge clk); #1 out_ready = 1'b0;
    ask("R9 stalled result");
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(out_valid == 1'b1, "R9 held valid", int'(out_valid), 1);
      check(req_ready == 1'b0, "R9 ready low while full", int'(req_ready), 0);
    end
    @(posedge clk); #1 out_ready = 1'b1;
    ask("R9 back to back a");
    ask("R9 back to back b");

    repeat (4) @(posedge clk);
    @(negedge clk);
    check(exp_q.size() == 0, "R9 all results delivered", exp_q.size(), 0);
    check(out_valid == 1'b0, "R9 drained", int'(out_valid), 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule